// File: doc/BRIEF.md
# SD Host Global Register Wrapper

This block is the shared front end of a host controller that serves one or two SD slots. Inside a 4 KiB address window it keeps a small file of 32-bit global registers: an information word with a self-clearing reset request, a debounce word, bus, write-protect polarity and card-detect words, and an interrupt status word. It also holds each slot's capability and maximum-current words. These are read and written through fixed global offsets, and their current values are driven out continuously to the slots.

The bus side is a simple request/response port. A request is taken when `req_ready` is high. One cycle later a single-cycle response carries the read data and an error flag. Accesses that fall into a slot's own 256-byte sub-window raise that slot's select line and leave the global file untouched. Accesses beyond the last slot window are answered with zero and flagged as errors. Each slot's interrupt line sets or clears its own status bit on its edges. The valid status bits are ORed into one interrupt output.

A two-state access machine sequences every transfer. In `ST_IDLE` it accepts a request. The transition IDLE→RESP happens on any accepted request, and RESP→IDLE happens unconditionally on the next edge. While in `ST_RESP` it presents the response.

Top module: `sdg_wrap`

## Requirements
- R1: A request is accepted in a cycle where `req` and `req_ready` are both high. `rsp_valid` is then high for exactly the following cycle, during which `req_ready` is low. A write returns `rdata` = 0.
- R2: Byte offset 0x000 is the information word. A write stores the value with bit 0 forced to 0, so bit 0 always reads back as 0.
- R3: After reset the information word reads 0x00010000 with one slot, and 0x00030000 with two slots (bit 16 marks slot 0, bit 17 marks slot 1).
- R4: After reset the debounce word at offset 0x004 reads 0x00000005. Every other global word reads 0.
- R5: For slot i, the capability word sits at offset 0x10+0x10·i and the maximum-current word at 0x18+0x10·i. Reads and writes there reach per-slot copies, which are driven on `slot_cap[32i+31:32i]` and `slot_maxcur[32i+31:32i]`. After reset they hold the parameter `CAP_RST` and 0.
- R6: In the interrupt status word at offset 0x0FC, bit n becomes 1 at the clock edge that samples a rise of `slot_irq[n]`. It becomes 0 at the edge that samples its fall. A line edge wins over a same-cycle software write to that bit.
- R7: The other offsets below 0x100, including bus 0x008, write-protect polarity 0x0EC and card detect 0x0F0, are plain read/write storage.
- R8: `irq_out` is the OR of status bits [NSLOT-1:0]. Any higher status bits are storage only.
- R9: An address at or above (NSLOT+1)·0x100 reads 0, changes no state, and raises `acc_err` in its response cycle only.
- R10: An address in slot i's window, (i+1)·0x100 to (i+1)·0x100+0xFF, raises `slot_sel[i]` combinationally in the accepting cycle. It changes no global state, and its response has `rdata` = 0 and no error.
- R11: A write to offset 0x000 with bit 0 set raises `slot_rst` for exactly one cycle, namely its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the window (word aligned) |
| wdata | input | 32 | Write data |
| req_ready | output | 1 | Request can be taken this cycle |
| rsp_valid | output | 1 | Response cycle |
| rdata | output | 32 | Read data during response |
| acc_err | output | 1 | Out-of-range access strobe |
| slot_sel | output | NSLOT | Pass-through select per slot window |
| slot_rst | output | 1 | One-cycle reset pulse toward slots |
| slot_irq | input | NSLOT | Interrupt line from each slot |
| irq_out | output | 1 | Combined interrupt |
| slot_cap | output | 32·NSLOT | Capability word per slot |
| slot_maxcur | output | 32·NSLOT | Maximum-current word per slot |

## Verification
The properties assume `slot_irq` is synchronous to `clk` and that `addr` is word aligned, since only full 32-bit accesses exist. The stimulus drives both on falling edges and uses only multiples of four. The bench also drops `req` after each acceptance and waits out the response before issuing another request. The properties on the information read-back and the out-of-range strobe rely on that spacing, so each response can be tied to exactly one captured address.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    typedef enum logic {ST_IDLE, ST_RESP} sdg_state_e;
    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int WIN_B   = 256;
    localparam int NWORDS  = WIN_B / 4;
    localparam int WIDX_W  = $clog2(NWORDS);
    localparam logic [WIDX_W-1:0] W_INFO = '0;
    localparam logic [WIDX_W-1:0] W_DEB  = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(NWORDS - 1);
    localparam logic [DW-1:0] DEB_RST = 32'h0000_0005;
endpackage

// File: rtl/sdg_decode.sv
module sdg_decode
    import sdg_pkg::*;
#(
    parameter int NSLOT = 2
) (
    input  logic [AW-1:0]     addr,
    output logic              glob_hit,
    output logic              oob,
    output logic [WIDX_W-1:0] word,
    output logic [NSLOT-1:0]  slot_hit,
    output logic [NSLOT-1:0]  cap_hit,
    output logic [NSLOT-1:0]  cur_hit
);
    localparam int PW = AW - 8;

    assign glob_hit = (addr[AW-1:8] == '0);
    assign word     = addr[7:2];

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [7:0] CAP_OFS = 8'(16 + 16 * i);
        localparam logic [7:0] CUR_OFS = 8'(24 + 16 * i);
        assign slot_hit[i] = (addr[AW-1:8] == PW'(i + 1));
        assign cap_hit[i]  = glob_hit && (addr[7:0] == CAP_OFS);
        assign cur_hit[i]  = glob_hit && (addr[7:0] == CUR_OFS);
    end

    assign oob = !glob_hit && !(|slot_hit);
endmodule

// File: rtl/sdg_irq_edge.sv
module sdg_irq_edge #(
    parameter int NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] lvl,
    output logic [NSLOT-1:0] rise,
    output logic [NSLOT-1:0] fall
);
    logic [NSLOT-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sdg_regfile.sv
module sdg_regfile
    import sdg_pkg::*;
#(
    parameter int          NSLOT   = 2,
    parameter logic [31:0] CAP_RST = 32'h0170_0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WIDX_W-1:0]   wr_word,
    input  logic [DW-1:0]       wdata,
    input  logic [NSLOT-1:0]    cap_wr,
    input  logic [NSLOT-1:0]    cur_wr,
    input  logic [NSLOT-1:0]    rise,
    input  logic [NSLOT-1:0]    fall,
    input  logic [WIDX_W-1:0]   rd_word,
    output logic [DW-1:0]       rd_data,
    output logic [NSLOT*DW-1:0] cap_q,
    output logic [NSLOT*DW-1:0] cur_q,
    output logic [NSLOT-1:0]    stat_q
);
    localparam logic [DW-1:0] INFO_RST =
        (NSLOT == 2) ? 32'h0003_0000 : 32'h0001_0000;

    logic [DW-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) mem[w] <= '0;
            mem[W_INFO] <= INFO_RST;
            mem[W_DEB]  <= DEB_RST;
        end else begin
            if (wr_en) begin
                if (wr_word == W_INFO) mem[wr_word] <= wdata & ~32'h1;
                else                   mem[wr_word] <= wdata;
            end
            for (int n = 0; n < NSLOT; n++) begin
                if (rise[n])      mem[W_STAT][n] <= 1'b1;
                else if (fall[n]) mem[W_STAT][n] <= 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_alias
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_q[i*DW +: DW] <= CAP_RST;
                cur_q[i*DW +: DW] <= '0;
            end else begin
                if (cap_wr[i]) cap_q[i*DW +: DW] <= wdata;
                if (cur_wr[i]) cur_q[i*DW +: DW] <= wdata;
            end
        end
    end

    assign rd_data = mem[rd_word];
    assign stat_q  = mem[W_STAT][NSLOT-1:0];
endmodule

// File: rtl/sdg_wrap.sv
module sdg_wrap
    import sdg_pkg::*;
#(
    parameter int          NSLOT   = 2,
    parameter logic [31:0] CAP_RST = 32'h0170_0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [11:0]         addr,
    input  logic [31:0]         wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [31:0]         rdata,
    output logic                acc_err,
    output logic [NSLOT-1:0]    slot_sel,
    output logic                slot_rst,
    input  logic [NSLOT-1:0]    slot_irq,
    output logic                irq_out,
    output logic [NSLOT*32-1:0] slot_cap,
    output logic [NSLOT*32-1:0] slot_maxcur
);
    sdg_state_e state_q, state_d;

    logic              glob_hit, oob, accept, rf_wr;
    logic [WIDX_W-1:0] word;
    logic [NSLOT-1:0]  slot_hit, cap_hit, cur_hit, rise, fall, stat;
    logic [DW-1:0]     rf_data, rd_mux;
    logic [DW-1:0]     rdata_q;
    logic              err_q, rst_q;

    sdg_decode #(.NSLOT(NSLOT)) u_dec (
        .addr(addr), .glob_hit(glob_hit), .oob(oob), .word(word),
        .slot_hit(slot_hit), .cap_hit(cap_hit), .cur_hit(cur_hit)
    );

    sdg_irq_edge #(.NSLOT(NSLOT)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(slot_irq), .rise(rise), .fall(fall)
    );

    sdg_regfile #(.NSLOT(NSLOT), .CAP_RST(CAP_RST)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_wr), .wr_word(word),
        .wdata(wdata), .cap_wr({NSLOT{accept & we}} & cap_hit),
        .cur_wr({NSLOT{accept & we}} & cur_hit), .rise(rise), .fall(fall),
        .rd_word(word), .rd_data(rf_data), .cap_q(slot_cap),
        .cur_q(slot_maxcur), .stat_q(stat)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
        endcase
    end

    assign accept   = req && req_ready;
    assign rf_wr    = accept && we && glob_hit && !(|cap_hit) && !(|cur_hit);
    assign slot_sel = {NSLOT{accept}} & slot_hit;

    always_comb begin
        rd_mux = '0;
        if (glob_hit) rd_mux = rf_data;
        for (int i = 0; i < NSLOT; i++) begin
            if (cap_hit[i]) rd_mux = slot_cap[i*DW +: DW];
            if (cur_hit[i]) rd_mux = slot_maxcur[i*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            rdata_q <= we ? '0 : rd_mux;
            err_q   <= oob;
            rst_q   <= we && glob_hit && (word == W_INFO) && wdata[0];
        end
    end

    assign rdata    = rdata_q;
    assign acc_err  = err_q;
    assign slot_rst = rst_q;
    assign irq_out  = |stat;
endmodule

// File: rtl/sdg_wrap_chk.sv
module sdg_wrap_chk #(
    parameter int NSLOT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [31:0]      rdata,
    input logic [11:0]      addr,
    input logic             acc_err,
    input logic [NSLOT-1:0] slot_sel,
    input logic             slot_rst,
    input logic [NSLOT-1:0] slot_irq,
    input logic             irq_out
);
    // R1
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_ready) |=> rsp_valid);
    // R1
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R2
    info_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(addr) == 12'h000) |-> !rdata[0]);
    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_irq[0]) |=> irq_out);
    // R9
    err_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> rsp_valid);
    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));
    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst |=> !slot_rst);
endmodule

bind sdg_wrap sdg_wrap_chk #(.NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rdata(rdata), .addr(addr), .acc_err(acc_err),
    .slot_sel(slot_sel), .slot_rst(slot_rst), .slot_irq(slot_irq),
    .irq_out(irq_out)
);

// File: tb/sdg_wrap_tb.sv
module sdg_wrap_tb;
    localparam int          NS  = 2;
    localparam logic [31:0] CAP = 32'h0170_0080;
    localparam int          NV  = 18;

    // {we, addr, wdata, expected rdata, expected err}
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0,         32'h0003_0000, 1'b0}, // R3
        {1'b0, 12'h004, 32'h0,         32'h0000_0005, 1'b0}, // R4
        {1'b0, 12'h0F0, 32'h0,         32'h0,         1'b0}, // R4
        {1'b0, 12'h010, 32'h0,         CAP,           1'b0}, // R5
        {1'b0, 12'h018, 32'h0,         32'h0,         1'b0}, // R5
        {1'b1, 12'h000, 32'h1234_5677, 32'h0,         1'b0}, // R1
        {1'b0, 12'h000, 32'h0,         32'h1234_5676, 1'b0}, // R2
        {1'b1, 12'h010, 32'hAAAA_0001, 32'h0,         1'b0}, // R5
        {1'b0, 12'h010, 32'h0,         32'hAAAA_0001, 1'b0}, // R5
        {1'b1, 12'h028, 32'h0000_0300, 32'h0,         1'b0}, // R5
        {1'b0, 12'h028, 32'h0,         32'h0000_0300, 1'b0}, // R5
        {1'b1, 12'h0EC, 32'hF0F0_F0F0, 32'h0,         1'b0}, // R7
        {1'b0, 12'h0EC, 32'h0,         32'hF0F0_F0F0, 1'b0}, // R7
        {1'b1, 12'h008, 32'h0000_0055, 32'h0,         1'b0}, // R7
        {1'b0, 12'h008, 32'h0,         32'h0000_0055, 1'b0}, // R7
        {1'b0, 12'h300, 32'h0,         32'h0,         1'b1}, // R9
        {1'b1, 12'h400, 32'hFFFF_FFFF, 32'h0,         1'b1}, // R9
        {1'b0, 12'h000, 32'h0,         32'h1234_5676, 1'b0}  // R9
    };

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic req_ready, rsp_valid, acc_err, slot_rst, irq_out;
    logic [31:0] rdata;
    logic [NS-1:0] slot_sel;
    logic [NS-1:0] slot_irq = '0;
    logic [NS*32-1:0] slot_cap, slot_maxcur;
    int checks = 0, errors = 0;
    logic [31:0] r_d;
    logic r_e, r_s;

    always #2.5 clk = ~clk;

    sdg_wrap #(.NSLOT(NS), .CAP_RST(CAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rdata(rdata), .acc_err(acc_err), .slot_sel(slot_sel),
        .slot_rst(slot_rst), .slot_irq(slot_irq), .irq_out(irq_out),
        .slot_cap(slot_cap), .slot_maxcur(slot_maxcur)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] rd,
                          output logic er, output logic rs);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk); #1;
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
        rd = rdata; er = acc_err; rs = slot_rst;
        req = 1'b0;
        @(posedge clk); #1;
        chk("R1 single-cycle rsp", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 R8 reset state
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R8 reset irq_out", 32'(irq_out), 32'd0);
        chk("R11 reset slot_rst", 32'(slot_rst), 32'd0);

        for (int k = 0; k < NV; k++) begin
            access(VEC[k][77], VEC[k][76:65], VEC[k][64:33], r_d, r_e, r_s);
            chk($sformatf("vec%0d rdata", k), r_d, VEC[k][32:1]);
            chk($sformatf("vec%0d R9 err", k), 32'(r_e), 32'(VEC[k][0]));
        end

        // R5 values driven to slots
        chk("R5 slot0 cap", slot_cap[31:0], 32'hAAAA_0001);
        chk("R5 slot1 cap", slot_cap[63:32], CAP);
        chk("R5 slot1 maxcur", slot_maxcur[63:32], 32'h0000_0300);

        // R10 slot window select
        @(negedge clk); req = 1'b1; we = 1'b1; addr = 12'h104; wdata = 32'h77;
        #1 chk("R10 sel slot0", 32'(slot_sel), 32'd1);
        @(posedge clk); #1;
        chk("R10 rsp err", 32'(acc_err), 32'd0);
        req = 1'b0;
        @(posedge clk);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = 12'h2F0;
        #1 chk("R10 sel slot1", 32'(slot_sel), 32'd2);
        @(posedge clk); #1;
        chk("R10 rsp data", rdata, 32'h0);
        req = 1'b0;
        @(posedge clk);
        access(1'b0, 12'h004, 32'h0, r_d, r_e, r_s);
        chk("R10 global untouched", r_d, 32'h5);

        // R11 reset pulse
        access(1'b1, 12'h000, 32'h0000_0001, r_d, r_e, r_s);
        chk("R11 slot_rst pulse", 32'(r_s), 32'd1);
        chk("R11 slot_rst cleared", 32'(slot_rst), 32'd0);
        access(1'b0, 12'h000, 32'h0, r_d, r_e, r_s);
        chk("R2 bit0 cleared", r_d, 32'h0);

        // R6 interrupt level tracking
        @(negedge clk); slot_irq = 2'b10;
        @(posedge clk); #1;
        chk("R6 R8 irq_out after rise", 32'(irq_out), 32'd1);
        access(1'b0, 12'h0FC, 32'h0, r_d, r_e, r_s);
        chk("R6 stat bit1 set", r_d, 32'h2);
        @(negedge clk); slot_irq = 2'b00;
        @(posedge clk); #1;
        chk("R6 irq_out after fall", 32'(irq_out), 32'd0);
        access(1'b0, 12'h0FC, 32'h0, r_d, r_e, r_s);
        chk("R6 stat bit1 cleared", r_d, 32'h0);

        // R8 software writes to status
        access(1'b1, 12'h0FC, 32'h0000_0004, r_d, r_e, r_s);
        chk("R8 high bit no irq", 32'(irq_out), 32'd0);
        access(1'b0, 12'h0FC, 32'h0, r_d, r_e, r_s);
        chk("R8 high bit stored", r_d, 32'h4);
        access(1'b1, 12'h0FC, 32'h0000_0001, r_d, r_e, r_s);
        chk("R8 valid bit irq", 32'(irq_out), 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule